// File: doc/BRIEF.md
# Register-Mapped Interrupt Expander

This block gathers up to sixteen peripheral interrupt requests into one sticky status register. It drives a single active-low, level-sensitive interrupt line to a host processor whenever a pending request is not masked. Each request first passes through a two-flop synchronizer. Request 0 is active low and the other requests are active high. The polarity of each request is a parameter.

The host reaches the block over a simple synchronous 16-bit register bus. The bus has an address, write data, read data, a read strobe and a write strobe. Through it software reads the status, reads and writes the mask, and writes a level-style clear register: a bit written high holds its status bit at zero until software writes the bit low again. Three fixed signature words sit at sparse offsets, so that software can confirm the block is present before it touches it. A further read-only word returns a parameterised code version.

The interrupt line is driven by a two-state machine. In `IRQ_IDLE` the line is high. In `IRQ_ACTIVE` the line is low. The `RAISE` transition goes from `IRQ_IDLE` to `IRQ_ACTIVE` when any status bit with a clear mask bit is pending. The `DROP` transition returns to `IRQ_IDLE` when no such bit remains. In every other case the machine stays in its current state.

Top module: `irqx_top`

## Requirements
- R1: After reset the status and clear registers read 0x0000, the mask reads 0xFFFF, and `host_irq_n` is high.
- R2: Offset 0x40 reads 0xAAAA, offset 0x48 reads 0x5555 and offset 0x58 reads 0xCAFE. Offset 0x50 reads the `CODE_VERSION` parameter, which defaults to 0x0103.
- R3: An asserted request sets its status bit three clock edges after the request is first sampled. The bit stays set after the request goes away, until software clears it.
- R4: Request bit 0 is asserted when its input is low. Request bits 1 to 15 are asserted when their inputs are high.
- R5: The mask at offset 0x38 is readable and writable. A 1 in bit n stops status bit n from driving the interrupt line, and a 0 in bit n lets it drive the line.
- R6: `host_irq_n` goes low one clock after any bit of (status AND NOT mask) becomes 1. It goes high one clock after no such bit remains.
- R7: The clear register at offset 0x20 reads back its value. While bit n of the clear register is 1, status bit n is forced to 0. After software writes 1 then 0, the status bit stays at 0 unless its request is still asserted. Writing 0xFFFF clears every bit.
- R8: Read data appears on `bus_rdata` in the clock after the read strobe and then holds. Reads of unmapped offsets return 0x0000.
- R9: Writes to the status offset 0x10, to the signature and version offsets, and to unmapped offsets leave every register unchanged.
- R10: The status register is readable at offset 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | 16 | Raw interrupt requests; bit 0 is active low, the other bits are active high |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe; the write takes effect on this clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| host_irq_n | output | 1 | Interrupt line to the host, active low, level sensitive |

## Verification
The bench holds a request at its asserted level through a clear pulse. Status must read zero while the clear bit is high and must set again once the clear is released. A design that clears on an edge, or that does not hold the bit while the clear is high, reads the wrong value at one of these two points.

The bench samples `host_irq_n` in the cycle right after a mask write and again one cycle later. A line driven straight from logic, or one delayed by an extra register, fails one of those two samples.

Request 0 is held at its idle high level while the other sources fire. This checks that its inverted polarity does not raise a false pending bit.

Writes to the status, signature and unmapped offsets are each followed by read-back. A decoder that aliases these offsets would corrupt a value that the read then exposes.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
    // Register byte offsets; software relies on these exact values.
    localparam int unsigned OFS_STATUS  = 'h10;
    localparam int unsigned OFS_CLEAR   = 'h20;
    localparam int unsigned OFS_MASK    = 'h38;
    localparam int unsigned OFS_SIG_A   = 'h40;
    localparam int unsigned OFS_SIG_B   = 'h48;
    localparam int unsigned OFS_VERSION = 'h50;
    localparam int unsigned OFS_SIG_C   = 'h58;

    // Presence signature words.
    localparam logic [15:0] SIG_A_WORD = 16'hAAAA;
    localparam logic [15:0] SIG_B_WORD = 16'h5555;
    localparam logic [15:0] SIG_C_WORD = 16'hCAFE;

    // Interrupt line state machine.
    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_t;
endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
    parameter int unsigned         SRC_N      = 16,
    parameter logic [SRC_N-1:0]    ACTIVE_LOW = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] raw_req,
    output logic [SRC_N-1:0] req_hi
);
    // Each bit gets its own two-flop chain, normalised to active high.
    for (genvar i = 0; i < SRC_N; i++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= raw_req[i] ^ ACTIVE_LOW[i];
                sync_q <= meta_q;
            end
        end
        assign req_hi[i] = sync_q;
    end
endmodule

// File: rtl/irqx_status.sv
module irqx_status #(
    parameter int unsigned SRC_N = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] req_hi,
    input  logic [SRC_N-1:0] clr_hold,
    output logic [SRC_N-1:0] status
);
    logic [SRC_N-1:0] status_d;

    always_comb begin
        status_d = (status | req_hi) & ~clr_hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= status_d;
    end

    // R7
    clr_forces_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_hold) |=> ((status & $past(clr_hold)) == '0));

    // R3
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & ~clr_hold)) |=>
            ((status & $past(status & ~clr_hold)) == $past(status & ~clr_hold)));
endmodule

// File: rtl/irqx_irq_fsm.sv
module irqx_irq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    output logic host_irq_n
);
    import irqx_pkg::*;

    irq_state_t state_q;
    irq_state_t state_d;

    // Next-state process.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (any_pend)  state_d = IRQ_ACTIVE; // RAISE
            IRQ_ACTIVE: if (!any_pend) state_d = IRQ_IDLE;   // DROP
            default:    state_d = IRQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    // Output process.
    always_comb begin
        unique case (state_q)
            IRQ_ACTIVE: host_irq_n = 1'b0;
            default:    host_irq_n = 1'b1;
        endcase
    end

    // R6
    irq_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (host_irq_n == !$past(any_pend)));
endmodule

// File: rtl/irqx_top.sv
module irqx_top #(
    parameter int unsigned      SRC_N        = 16,
    parameter int unsigned      DATA_W       = 16,
    parameter int unsigned      ADDR_W       = 8,
    parameter logic [SRC_N-1:0] ACTIVE_LOW   = 16'h0001,
    parameter logic [15:0]      CODE_VERSION = 16'h0103
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              host_irq_n
);
    import irqx_pkg::*;

    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_CLEAR   = ADDR_W'(OFS_CLEAR);
    localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_SIG_A   = ADDR_W'(OFS_SIG_A);
    localparam logic [ADDR_W-1:0] A_SIG_B   = ADDR_W'(OFS_SIG_B);
    localparam logic [ADDR_W-1:0] A_VERSION = ADDR_W'(OFS_VERSION);
    localparam logic [ADDR_W-1:0] A_SIG_C   = ADDR_W'(OFS_SIG_C);

    logic [SRC_N-1:0]  req_hi;
    logic [SRC_N-1:0]  status;
    logic [SRC_N-1:0]  mask_q;
    logic [SRC_N-1:0]  clr_q;
    logic              any_pend;
    logic [DATA_W-1:0] rd_mux;

    irqx_sync #(.SRC_N(SRC_N), .ACTIVE_LOW(ACTIVE_LOW)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_req (src_req),
        .req_hi  (req_hi)
    );

    irqx_status #(.SRC_N(SRC_N)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_hi   (req_hi),
        .clr_hold (clr_q),
        .status   (status)
    );

    // Writable registers: only mask and clear accept data.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            clr_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_MASK)  mask_q <= bus_wdata[SRC_N-1:0];
            if (bus_addr == A_CLEAR) clr_q  <= bus_wdata[SRC_N-1:0];
        end
    end

    assign any_pend = |(status & ~mask_q);

    irqx_irq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_pend   (any_pend),
        .host_irq_n (host_irq_n)
    );

    // Read decode.
    always_comb begin
        case (bus_addr)
            A_STATUS:  rd_mux = DATA_W'(status);
            A_CLEAR:   rd_mux = DATA_W'(clr_q);
            A_MASK:    rd_mux = DATA_W'(mask_q);
            A_SIG_A:   rd_mux = DATA_W'(SIG_A_WORD);
            A_SIG_B:   rd_mux = DATA_W'(SIG_B_WORD);
            A_VERSION: rd_mux = DATA_W'(CODE_VERSION);
            A_SIG_C:   rd_mux = DATA_W'(SIG_C_WORD);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // R2
    sig_a_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_SIG_A) |=> (bus_rdata == DATA_W'(SIG_A_WORD)));

    // R2
    sig_c_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_SIG_C) |=> (bus_rdata == DATA_W'(SIG_C_WORD)));

    // R5
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MASK) |=> (mask_q == $past(bus_wdata[SRC_N-1:0])));

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R9
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != A_MASK && bus_addr != A_CLEAR) |=>
            ($stable(mask_q) && $stable(clr_q)));
endmodule

// File: tb/tb_irqx_top.sv
module tb_irqx_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_req = 16'h0001;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        host_irq_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    irqx_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_req    (src_req),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .host_irq_n (host_irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: issue a read and push the expected word to the scoreboard.
    task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_addr = a;
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        total++;
        if (host_irq_n !== e) begin
            bad++;
            $display("FAIL %s host_irq_n actual=%b expected=%b", tag, host_irq_n, e);
        end
    endtask

    // Monitor: compare read data in the cycle after each read strobe.
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                if (exp_q.size() > 0) begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    total++;
                    if (bus_rdata !== e) begin
                        bad++;
                        $display("FAIL %s rdata actual=%h expected=%h", t, bus_rdata, e);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk_irq(1'b1, "R1");
        rd(8'h10, 16'h0000, "R1 status");
        rd(8'h38, 16'hFFFF, "R1 mask");
        rd(8'h20, 16'h0000, "R1 clear");
        // R2 signatures and version
        rd(8'h40, 16'hAAAA, "R2 sig a");
        rd(8'h48, 16'h5555, "R2 sig b");
        rd(8'h58, 16'hCAFE, "R2 sig c");
        rd(8'h50, 16'h0103, "R2 version");
        // R8 unmapped reads
        rd(8'h00, 16'h0000, "R8 unmapped 00");
        rd(8'h44, 16'h0000, "R8 unmapped 44");
        rd(8'h5C, 16'h0000, "R8 unmapped 5c");
        // R9 writes to read-only or unmapped offsets
        wr(8'h10, 16'h1234);
        wr(8'h40, 16'h0000);
        wr(8'h30, 16'h0F0F);
        tick(1);
        rd(8'h10, 16'h0000, "R9 status after write");
        rd(8'h40, 16'hAAAA, "R9 sig after write");
        rd(8'h38, 16'hFFFF, "R9 mask after write");
        rd(8'h20, 16'h0000, "R9 clear after write");

        // R3 request on bit 3, masked
        src_req = 16'h0009;
        tick(4);
        rd(8'h10, 16'h0008, "R3 status set");
        chk_irq(1'b1, "R5 masked source");
        // R6 latency after unmask
        wr(8'h38, 16'hFFF7);
        chk_irq(1'b1, "R6 one cycle after mask write");
        tick(1);
        chk_irq(1'b0, "R6 asserted");
        rd(8'h38, 16'hFFF7, "R5 mask readback");
        // R3 sticky after request removed
        src_req = 16'h0001;
        tick(4);
        rd(8'h10, 16'h0008, "R3 sticky");
        chk_irq(1'b0, "R3 irq held");
        // R7 clear pulse
        wr(8'h20, 16'h0008);
        tick(1);
        rd(8'h20, 16'h0008, "R7 clear readback");
        rd(8'h10, 16'h0000, "R7 status cleared");
        wr(8'h20, 16'h0000);
        tick(2);
        chk_irq(1'b1, "R7 irq released");
        rd(8'h10, 16'h0000, "R7 status stays clear");

        // R4 bit 0 is active low
        src_req = 16'h0000;
        tick(4);
        rd(8'h10, 16'h0001, "R4 bit0 low sets");
        wr(8'h38, 16'hFFFE);
        tick(1);
        chk_irq(1'b0, "R4 irq from bit0");
        // R7 hold while request still asserted
        wr(8'h20, 16'hFFFF);
        tick(1);
        rd(8'h10, 16'h0000, "R7 held at zero");
        tick(1);
        chk_irq(1'b1, "R7 irq while held");
        wr(8'h20, 16'h0000);
        tick(1);
        rd(8'h10, 16'h0001, "R7 level request re-sets");
        src_req = 16'h0001;
        tick(4);
        wr(8'h20, 16'hFFFF);
        wr(8'h20, 16'h0000);
        tick(2);
        rd(8'h10, 16'h0000, "R7 all cleared");
        chk_irq(1'b1, "R4 bit0 idle high gives no irq");

        // R5 multiple sources, selective masking
        src_req = 16'h0221;
        tick(4);
        src_req = 16'h0001;
        wr(8'h38, 16'hFDFF);
        tick(1);
        chk_irq(1'b0, "R5 bit9 enabled");
        rd(8'h10, 16'h0220, "R10 status two bits");
        wr(8'h38, 16'hFFFF);
        tick(1);
        chk_irq(1'b1, "R5 all masked");
        wr(8'h38, 16'hFFDF);
        tick(1);
        chk_irq(1'b0, "R5 bit5 enabled");
        wr(8'h20, 16'h0020);
        wr(8'h20, 16'h0000);
        tick(2);
        chk_irq(1'b1, "R6 drop after clearing bit5");
        rd(8'h10, 16'h0200, "R7 only bit5 cleared");

        tick(3);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule